// File: doc/BRIEF.md
# Amplifier Fault Protection Controller

This block decides when the power stage of a pulse-density-modulated audio amplifier must be tri-stated. It watches the incoming 1-bit data stream, sampled on a bit strobe, and flags a data-loss fault when too many equal bits arrive in a row. A long run of zeros and a long run of ones both count as lost data. The fault drops on the first bit that differs from its predecessor.

An external over-temperature comparator flag sets a thermal fault. The fault stays latched while a cycle-counting timer runs. When the timer expires, the fault clears if the flag is low. If the flag is still high, the fault re-arms and the timer starts again. While either fault is set, the float control output is high and the output stage stays off.

Top module: `amp_fault_guard`

## Requirements
- R1: After reset, `data_lost`, `heat_fault` and `stage_float` are 0 and `run_len` is 0.
- R2: Each strobed bit that equals the previous strobed bit raises `run_len` by one. A bit that differs, and the first bit after reset, set `run_len` to 1. Cycles without a strobe leave `run_len` unchanged.
- R3: `run_len` saturates at RUN_LIMIT (default 128) and never wraps while the stream stays stuck.
- R4: `data_lost` is 1 exactly when `run_len` equals RUN_LIMIT. This holds for a run of zeros and for a run of ones. `data_lost` rises in the cycle after the strobe that completes the run.
- R5: `data_lost` falls in the cycle after the first strobed bit that differs from the stuck value.
- R6: A high `over_temp` sets `heat_fault` in the next cycle and loads the timer with HOLD_CYCLES.
- R7: The timer counts down one per cycle while `heat_fault` is set, and `over_temp` has no effect on it until it expires. When it expires with `over_temp` low, `heat_fault` clears. With `over_temp` high, the fault stays set and the timer reloads.
- R8: `stage_float` is 1 exactly when `data_lost` or `heat_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdm_bit | input | 1 | Incoming PDM data bit |
| pdm_stb | input | 1 | High for one cycle when `pdm_bit` is valid |
| over_temp | input | 1 | Over-temperature comparator flag |
| stage_float | output | 1 | 1 = tri-state the output stage |
| data_lost | output | 1 | Data-loss fault status |
| heat_fault | output | 1 | Thermal fault status |
| run_len | output | RUN_W | Length of the current run of identical bits, saturating |

## Verification
The assertions assume that `pdm_stb` and `over_temp` are synchronous to `clk` and that `pdm_bit` is only sampled while `pdm_stb` is high. The stimulus changes every input half a period away from the rising edge. The bench uses a short HOLD_CYCLES of 40 so that timer expiry can be seen. The strobe is spaced at every second cycle, with idle gaps, to show that the run count holds between strobes.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;
   typedef enum logic [1:0] {
      TH_IDLE = 2'b00,
      TH_HOLD = 2'b01
   } heat_state_e;

   function automatic int unsigned bits_for(input int unsigned val);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= val) w++;
      return w;
   endfunction
endpackage

// File: rtl/run_watch.sv
module run_watch #(
   parameter int unsigned RUN_LIMIT = 128,
   parameter int unsigned RUN_W     = amp_fault_pkg::bits_for(RUN_LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_in,
   input  logic             bit_stb,
   output logic [RUN_W-1:0] run_cnt,
   output logic             stuck
);
   localparam logic [RUN_W-1:0] LIMIT_V = RUN_W'(RUN_LIMIT);
   localparam logic [RUN_W-1:0] ONE_V   = RUN_W'(1);

   initial begin
      if (RUN_LIMIT < 2) $error("run_watch: RUN_LIMIT must be at least 2");
   end

   logic             prev_bit;
   logic             have_prev;
   logic [RUN_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = run_cnt;
      if (bit_stb) begin
         if (!have_prev || (bit_in != prev_bit)) cnt_nxt = ONE_V;
         else if (run_cnt != LIMIT_V)          cnt_nxt = run_cnt + ONE_V;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         prev_bit  <= 1'b0;
         have_prev <= 1'b0;
         stuck     <= 1'b0;
      end else begin
         run_cnt <= cnt_nxt;
         stuck   <= (cnt_nxt == LIMIT_V);
         if (bit_stb) begin
            prev_bit  <= bit_in;
            have_prev <= 1'b1;
         end
      end
   end

   // R3
   run_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= LIMIT_V);
   // R3
   run_hold_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == LIMIT_V && bit_stb && bit_in == prev_bit) |=> run_cnt == LIMIT_V);
   // R2
   run_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(run_cnt));
   // R5
   run_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && have_prev && bit_in != prev_bit) |=> (run_cnt == ONE_V && !stuck));
endmodule

// File: rtl/heat_timer.sv
module heat_timer #(
   parameter int unsigned HOLD_CYCLES = 614400,
   parameter int unsigned TMR_W       = amp_fault_pkg::bits_for(HOLD_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_flag,
   output logic fault
);
   import amp_fault_pkg::*;
   localparam logic [TMR_W-1:0] LOAD_V = TMR_W'(HOLD_CYCLES - 1);

   initial begin
      if (HOLD_CYCLES < 2) $error("heat_timer: HOLD_CYCLES must be at least 2");
   end

   heat_state_e      st;
   logic [TMR_W-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= TH_IDLE;
         tmr <= '0;
      end else begin
         case (st)
            TH_IDLE: if (hot_flag) begin
               st  <= TH_HOLD;
               tmr <= LOAD_V;
            end
            default: begin
               if (tmr != '0) tmr <= tmr - 1'b1;
               else if (hot_flag) tmr <= LOAD_V;
               else st <= TH_IDLE;
            end
         endcase
      end
   end

   assign fault = (st == TH_HOLD);

   // R6
   heat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault && hot_flag) |=> fault);
   // R7
   heat_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && tmr != '0) |=> (fault && tmr == $past(tmr) - 1'b1));
   // R7
   heat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && tmr == '0 && !hot_flag) |=> !fault);
   // R7
   heat_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && tmr == '0 && hot_flag) |=> (fault && tmr == LOAD_V));
endmodule

// File: rtl/amp_fault_guard.sv
module amp_fault_guard #(
   parameter int unsigned RUN_LIMIT   = 128,
   parameter int unsigned HOLD_CYCLES = 614400,
   parameter int unsigned RUN_W       = amp_fault_pkg::bits_for(RUN_LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pdm_bit,
   input  logic             pdm_stb,
   input  logic             over_temp,
   output logic             stage_float,
   output logic             data_lost,
   output logic             heat_fault,
   output logic [RUN_W-1:0] run_len
);
   localparam int unsigned TMR_W = amp_fault_pkg::bits_for(HOLD_CYCLES);

   initial begin
      if (RUN_W < amp_fault_pkg::bits_for(RUN_LIMIT))
         $error("amp_fault_guard: RUN_W too narrow for RUN_LIMIT");
   end

   run_watch #(.RUN_LIMIT(RUN_LIMIT), .RUN_W(RUN_W)) u_run (
      .clk(clk), .rst_n(rst_n), .bit_in(pdm_bit), .bit_stb(pdm_stb),
      .run_cnt(run_len), .stuck(data_lost)
   );

   heat_timer #(.HOLD_CYCLES(HOLD_CYCLES), .TMR_W(TMR_W)) u_heat (
      .clk(clk), .rst_n(rst_n), .hot_flag(over_temp), .fault(heat_fault)
   );

   assign stage_float = data_lost | heat_fault;

   // R4
   lost_matches_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_lost == (run_len == RUN_W'(RUN_LIMIT)));
   // R8
   float_when_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_lost || heat_fault) |-> stage_float);
endmodule

// File: tb/test_amp_fault_guard.sv
`timescale 1ns/1ps
module test_amp_fault_guard;
   localparam int unsigned LIM  = 128;
   localparam int unsigned HOLD = 40;
   localparam int unsigned W    = 8;

   logic clk = 0, rst_n = 0, pdm_bit = 0, pdm_stb = 0, over_temp = 0;
   logic stage_float, data_lost, heat_fault;
   logic [W-1:0] run_len;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   amp_fault_guard #(.RUN_LIMIT(LIM), .HOLD_CYCLES(HOLD), .RUN_W(W)) i_amp_fault_guard (
      .clk, .rst_n, .pdm_bit, .pdm_stb, .over_temp,
      .stage_float, .data_lost, .heat_fault, .run_len);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive at negedge, result visible after next posedge; sample at following negedge
   task automatic send_bit(input logic b);
      @(negedge clk); pdm_bit = b; pdm_stb = 1;
      @(negedge clk); pdm_stb = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0; pdm_stb = 0; over_temp = 0;
      @(negedge clk); rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 data_lost", data_lost, 0);
      chk("R1 heat_fault", heat_fault, 0);
      chk("R1 stage_float", stage_float, 0);
      chk("R1 run_len", run_len, 0);
   endtask

   task automatic t_count();
      do_reset();
      send_bit(1);
      chk("R2 first bit", run_len, 1);
      send_bit(1); send_bit(1);
      chk("R2 run of three", run_len, 3);
      repeat (5) @(negedge clk);
      chk("R2 idle hold", run_len, 3);
      send_bit(0);
      chk("R2 differing bit", run_len, 1);
      for (int i = 0; i < 10; i++) send_bit(i[0]);
      chk("R2 alternating", run_len, 1);
      chk("R4 no loss alternating", data_lost, 0);
   endtask

   task automatic t_stuck(input logic v, input string tag);
      do_reset();
      for (int i = 0; i < LIM - 1; i++) send_bit(v);
      chk({tag, " R4 one below limit"}, data_lost, 0);
      chk({tag, " R4 run below limit"}, run_len, LIM - 1);
      send_bit(v);
      chk({tag, " R4 asserted"}, data_lost, 1);
      chk({tag, " R8 float"}, stage_float, 1);
      for (int i = 0; i < 20; i++) send_bit(v);
      chk({tag, " R3 saturated"}, run_len, LIM);
      chk({tag, " R3 still lost"}, data_lost, 1);
      send_bit(~v);
      chk({tag, " R5 cleared"}, data_lost, 0);
      chk({tag, " R5 run restart"}, run_len, 1);
      chk({tag, " R8 float off"}, stage_float, 0);
   endtask

   task automatic t_heat_release();
      do_reset();
      @(negedge clk); over_temp = 1;
      @(negedge clk); over_temp = 0;
      chk("R6 fault set", heat_fault, 1);
      chk("R8 float on heat", stage_float, 1);
      repeat (HOLD - 2) @(negedge clk);
      chk("R7 still held", heat_fault, 1);
      repeat (2) @(negedge clk);
      chk("R7 released", heat_fault, 0);
      chk("R8 float released", stage_float, 0);
   endtask

   task automatic t_heat_rearm();
      do_reset();
      @(negedge clk); over_temp = 1;
      repeat (HOLD + 5) @(negedge clk);
      chk("R7 rearm held", heat_fault, 1);
      over_temp = 0;
      repeat (2 * HOLD + 2) @(negedge clk);
      chk("R7 released after rearm", heat_fault, 0);
   endtask

   initial begin
      t_reset();
      t_count();
      t_stuck(1'b0, "zeros");
      t_stuck(1'b1, "ones");
      t_heat_release();
      t_heat_rearm();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule